// File: doc/BRIEF.md
# OSD Host Write Front End

This block receives write transfers from a 32-bit host bus and prepares them for an on-screen-display overlay. Each write carries a byte address, and the address selects where the word goes: into a first-in first-out store of overlay content, or into one of three control registers. Content words are kept unchanged as 32-bit entries. The pixel path downstream reads them one at a time through a show-ahead read port.

The control registers fall into two groups. The immediate group takes effect on the clock edge after the write: a soft reset bit, an overlay enable bit and a pixel width select. The frame-aligned group holds the horizontal and vertical start of the overlay window. Writes to these go to a shadow copy, and the active copy takes the shadow value only when the video side signals frame start, so the window never moves in the middle of a frame. The block also watches the content store. When the store becomes full or becomes empty, the block sends a one-cycle event pulse so the host can pace its DMA bursts.

The host bus strobes are taken as already synchronous to `clk`.

Top module: `osd_host_frontend`

## Requirements
- R1: A write to byte address 0x00 is stored in the content FIFO as an unchanged 32-bit word when the FIFO is not full. `pix_word` shows the oldest stored word whenever `fifo_empty` is 0. Asserting `pix_rd` at a clock edge removes that word, so words leave in the order they were written.
- R2: Address 0x04 writes the control register. Address 0x08 writes the X start and address 0x0C writes the Y start. A write to any other address changes no output and stores nothing.
- R3: In the control register, bit 1 is the overlay enable and bit 2 is the pixel width select (1 selects 16-bit pixels, 0 selects 8-bit). `osd_enable` and `pix_wide` show the written bits from the clock edge after the write.
- R4: Writes to the X start and Y start (low COORD_W bits of the data) go to a shadow copy. `win_x` and `win_y` keep their values until a clock edge at which `frame_start` is 1. At that edge they take the shadow values.
- R5: Control bit 0 is a soft reset. While it is set, X and Y writes are ignored. From the second clock edge after the write that sets it, the FIFO is empty and the shadow and active positions are zero, and they stay that way while the bit remains set. A FIFO write made while the bit is set is discarded.
- R6: A FIFO write while `fifo_full` is 1 is discarded and sets `fifo_overflow`. `fifo_overflow` stays set until the next control register write clears it.
- R7: `evt_full` is high for exactly one cycle, the cycle in which `fifo_full` has just changed from 0 to 1.
- R8: `evt_empty` is high for exactly one cycle, the cycle in which `fifo_empty` has just changed from 0 to 1. Coming out of reset does not produce this pulse.
- R9: After reset the outputs have these values: `fifo_empty`=1, `fifo_full`=0, `osd_enable`=0, `pix_wide`=0, `win_x`=0, `win_y`=0, `fifo_overflow`=0, and both event pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe, one cycle per word |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| frame_start | input | 1 | Video frame start strobe |
| pix_rd | input | 1 | Pixel path takes the head word |
| pix_word | output | DATA_W | Oldest FIFO word (show-ahead) |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| osd_enable | output | 1 | Overlay enable |
| pix_wide | output | 1 | 1 = 16-bit pixels, 0 = 8-bit |
| win_x | output | COORD_W | Active window X start |
| win_y | output | COORD_W | Active window Y start |
| fifo_overflow | output | 1 | Sticky dropped-write flag |
| evt_full | output | 1 | One-cycle pulse when the FIFO becomes full |
| evt_empty | output | 1 | One-cycle pulse when the FIFO becomes empty |

## Verification
The bench builds the block with DEPTH=4, and leaves DATA_W=32, ADDR_W=8 and COORD_W=12 at their defaults. With the shallow store, the full edge, the overflow drop and the return to empty can each be reached within a few writes. An 8-bit address also makes an undecoded address (0x10) reachable for the ignore case. Coordinates up to 12 bits are enough to tell the shadow value from the active value across a frame start and a soft reset.

// File: rtl/osd_host_pkg.sv
// Package: register offsets and control bit positions shared by the
// front end and its submodules. Assumes byte addressing with 32-bit words.
package osd_host_pkg;
    localparam int OFS_FIFO  = 'h00;
    localparam int OFS_CTRL  = 'h04;
    localparam int OFS_XPOS  = 'h08;
    localparam int OFS_YPOS  = 'h0C;

    localparam int CTL_SOFT  = 0;
    localparam int CTL_EN    = 1;
    localparam int CTL_WIDE  = 2;

    typedef struct packed {
        logic fifo;
        logic ctrl;
        logic xpos;
        logic ypos;
    } wr_sel_t;
endpackage

// File: rtl/osd_host_fifo.sv
// Content FIFO: DEPTH words of DATA_W bits with a show-ahead read port.
// Assumes the caller gates push with !full and pop with !empty is not
// required (gating is done here). Flush empties it on the next edge.
module osd_host_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_push, do_pop;

    // qualified push and pop
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign pop_data = mem[rd_ptr];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= push_data;
    end

    // pointers and occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> full);

    // R5
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/osd_host_regs.sv
// Register file: immediate control bits plus shadow/active window position.
// Assumes one-hot write selects from the address decoder. Active position
// loads from the shadow at frame_start; soft reset zeroes both copies.
module osd_host_regs #(
    parameter int DATA_W  = 32,
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_we,
    input  logic               x_we,
    input  logic               y_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               frame_start,
    input  logic               fifo_wr_req,
    input  logic               fifo_full,
    output logic               soft_rst,
    output logic               osd_en,
    output logic               pix_wide,
    output logic [COORD_W-1:0] win_x,
    output logic [COORD_W-1:0] win_y,
    output logic               overflow
);
    import osd_host_pkg::*;

    logic [COORD_W-1:0] shadow_x, shadow_y;

    // immediate control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_rst <= 1'b0;
            osd_en   <= 1'b0;
            pix_wide <= 1'b0;
        end else if (ctl_we) begin
            soft_rst <= wdata[CTL_SOFT];
            osd_en   <= wdata[CTL_EN];
            pix_wide <= wdata[CTL_WIDE];
        end
    end

    // shadow position, written by the host
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            shadow_x <= '0;
            shadow_y <= '0;
        end else begin
            if (x_we) shadow_x <= wdata[COORD_W-1:0];
            if (y_we) shadow_y <= wdata[COORD_W-1:0];
        end
    end

    // active position, loaded at frame start
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            win_x <= '0;
            win_y <= '0;
        end else if (frame_start) begin
            win_x <= shadow_x;
            win_y <= shadow_y;
        end
    end

    // sticky overflow: set on dropped write, cleared by a control write
    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (fifo_wr_req && fifo_full)
            overflow <= 1'b1;
        else if (ctl_we)
            overflow <= 1'b0;
    end

    // R4
    window_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !soft_rst) |=> ($stable(win_x) && $stable(win_y)));

    // R5
    soft_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (win_x == '0 && win_y == '0));

    // R6
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !overflow ##1 overflow |-> $past(fifo_wr_req && fifo_full));
endmodule

// File: rtl/osd_host_evt.sv
// Event generator: one pulse per rising edge of each watched condition.
// Assumes conditions are glitch-free registered-domain signals; IDLE gives
// each condition's value after reset so reset itself makes no pulse.
module osd_host_evt #(
    parameter int        N    = 2,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    output logic [N-1:0] pulse
);
    logic [N-1:0] cond_q;

    for (genvar i = 0; i < N; i++) begin : g_edge
        // remember previous condition value
        always_ff @(posedge clk) begin
            if (!rst_n)
                cond_q[i] <= IDLE[i];
            else
                cond_q[i] <= cond[i];
        end

        assign pulse[i] = cond[i] && !cond_q[i];

        // R7 R8
        single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[i] |=> !pulse[i]);
    end
endmodule

// File: rtl/osd_host_frontend.sv
// Top: decodes host writes to the content FIFO or register file, and
// turns FIFO full/empty rises into event pulses. Assumes host strobes are
// already synchronous to clk and one word is written per strobe cycle.
module osd_host_frontend #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int DEPTH   = 16,
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               frame_start,
    input  logic               pix_rd,
    output logic [DATA_W-1:0]  pix_word,
    output logic               fifo_empty,
    output logic               fifo_full,
    output logic               osd_enable,
    output logic               pix_wide,
    output logic [COORD_W-1:0] win_x,
    output logic [COORD_W-1:0] win_y,
    output logic               fifo_overflow,
    output logic               evt_full,
    output logic               evt_empty
);
    import osd_host_pkg::*;

    wr_sel_t    sel;
    logic       soft_rst;
    logic       pos_we_ok;
    logic [1:0] evt_vec;

    // address decode into one-hot write selects
    always_comb begin
        sel      = '0;
        sel.fifo = host_we && (host_addr == ADDR_W'(OFS_FIFO));
        sel.ctrl = host_we && (host_addr == ADDR_W'(OFS_CTRL));
        sel.xpos = host_we && (host_addr == ADDR_W'(OFS_XPOS));
        sel.ypos = host_we && (host_addr == ADDR_W'(OFS_YPOS));
    end

    assign pos_we_ok = !soft_rst;

    osd_host_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (soft_rst),
        .push      (sel.fifo),
        .push_data (host_wdata),
        .pop       (pix_rd),
        .pop_data  (pix_word),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    osd_host_regs #(.DATA_W(DATA_W), .COORD_W(COORD_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_we      (sel.ctrl),
        .x_we        (sel.xpos && pos_we_ok),
        .y_we        (sel.ypos && pos_we_ok),
        .wdata       (host_wdata),
        .frame_start (frame_start),
        .fifo_wr_req (sel.fifo),
        .fifo_full   (fifo_full),
        .soft_rst    (soft_rst),
        .osd_en      (osd_enable),
        .pix_wide    (pix_wide),
        .win_x       (win_x),
        .win_y       (win_y),
        .overflow    (fifo_overflow)
    );

    osd_host_evt #(.N(2), .IDLE(2'b10)) evt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  ({fifo_empty, fifo_full}),
        .pulse (evt_vec)
    );

    assign evt_full  = evt_vec[0];
    assign evt_empty = evt_vec[1];

    // R7
    evt_full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_full |-> fifo_full);

    // R8
    evt_empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_empty |-> fifo_empty);

    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: tb/osd_host_frontend_tb_top.sv
`timescale 1ns/1ps
module osd_host_frontend_tb_top;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int DEPTH   = 4;
    localparam int COORD_W = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_we = 1'b0;
    logic [ADDR_W-1:0]  host_addr = '0;
    logic [DATA_W-1:0]  host_wdata = '0;
    logic               frame_start = 1'b0;
    logic               pix_rd = 1'b0;
    logic [DATA_W-1:0]  pix_word;
    logic               fifo_empty, fifo_full, osd_enable, pix_wide;
    logic [COORD_W-1:0] win_x, win_y;
    logic               fifo_overflow, evt_full, evt_empty;

    int vectors = 0;
    int miscompares = 0;
    int model_cnt = 0;
    bit model_soft = 0;
    bit done = 0;
    logic [DATA_W-1:0] exp_q [$];

    always #2 clk = ~clk;

    osd_host_frontend #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH),
                        .COORD_W(COORD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .frame_start(frame_start), .pix_rd(pix_rd),
        .pix_word(pix_word), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .osd_enable(osd_enable), .pix_wide(pix_wide), .win_x(win_x),
        .win_y(win_y), .fifo_overflow(fifo_overflow), .evt_full(evt_full),
        .evt_empty(evt_empty)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // driver: one write, expected FIFO contents pushed to the scoreboard
    task automatic host_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        if (a == 8'h00 && !model_soft && model_cnt < DEPTH) begin
            exp_q.push_back(d);
            model_cnt++;
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic pix_read();
        @(negedge clk);
        pix_rd = 1'b1;
        if (model_cnt > 0) model_cnt--;
        @(negedge clk);
        pix_rd = 1'b0;
    endtask

    task automatic frame_pulse();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // monitor: compare head word against the scoreboard on each read
    always @(negedge clk) begin
        #1;
        if (pix_rd && !fifo_empty) begin
            if (exp_q.size() == 0)
                check("R1 unexpected word", pix_word, 32'hDEAD_0000);
            else
                check("R1 fifo word", pix_word, exp_q.pop_front());
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 empty", fifo_empty, 1);
        check("R9 full", fifo_full, 0);
        check("R9 enable", osd_enable, 0);
        check("R9 wide", pix_wide, 0);
        check("R9 x", win_x, 0);
        check("R9 y", win_y, 0);
        check("R9 overflow", fifo_overflow, 0);
        check("R8 no empty pulse after reset", evt_empty, 0);
        check("R9 evt_full", evt_full, 0);

        // R3 enable and 16-bit width
        host_write(8'h04, 32'h6);
        check("R3 enable", osd_enable, 1);
        check("R3 wide", pix_wide, 1);

        // R1 fill, R7 full pulse
        host_write(8'h00, 32'hA5A5_0001);
        check("R1 not empty", fifo_empty, 0);
        check("R8 no pulse on push", evt_empty, 0);
        host_write(8'h00, 32'h1234_5678);
        host_write(8'h00, 32'hFFFF_0000);
        check("R7 not yet full", fifo_full, 0);
        host_write(8'h00, 32'h0BAD_CAFE);
        check("R7 full", fifo_full, 1);
        check("R7 evt_full pulse", evt_full, 1);
        @(negedge clk);
        check("R7 evt_full one cycle", evt_full, 0);

        // R6 overflow drop
        host_write(8'h00, 32'h5555_5555);
        check("R6 overflow set", fifo_overflow, 1);
        check("R6 still full", fifo_full, 1);
        check("R7 no repeat pulse", evt_full, 0);

        // R1 drain, R8 empty pulse
        pix_read(); pix_read(); pix_read();
        check("R8 not empty before last", fifo_empty, 0);
        pix_read();
        check("R6 dropped word not stored", fifo_empty, 1);
        check("R8 evt_empty pulse", evt_empty, 1);
        @(negedge clk);
        check("R8 evt_empty one cycle", evt_empty, 0);
        check("R6 overflow sticky", fifo_overflow, 1);

        // R6 clear by control write, R3 8-bit width
        host_write(8'h04, 32'h2);
        check("R6 overflow cleared", fifo_overflow, 0);
        check("R3 enable kept", osd_enable, 1);
        check("R3 narrow", pix_wide, 0);

        // R4 shadow then frame start
        host_write(8'h08, 32'h123);
        host_write(8'h0C, 32'h045);
        check("R4 x held", win_x, 0);
        check("R4 y held", win_y, 0);
        repeat (3) @(negedge clk);
        check("R4 x held idle", win_x, 0);
        frame_pulse();
        check("R4 x loaded", win_x, 12'h123);
        check("R4 y loaded", win_y, 12'h045);

        // R2 undecoded address ignored
        host_write(8'h10, 32'h7);
        check("R2 fifo untouched", fifo_empty, 1);
        check("R2 enable untouched", osd_enable, 1);
        check("R2 wide untouched", pix_wide, 0);
        frame_pulse();
        check("R2 x untouched", win_x, 12'h123);
        check("R2 y untouched", win_y, 12'h045);

        // R5 soft reset
        host_write(8'h00, 32'h1111_1111);
        host_write(8'h00, 32'h2222_2222);
        host_write(8'h08, 32'h300);
        host_write(8'h04, 32'h1);
        model_soft = 1;
        @(negedge clk);
        exp_q.delete();
        model_cnt = 0;
        check("R5 fifo flushed", fifo_empty, 1);
        check("R8 pulse on flush", evt_empty, 1);
        check("R5 x zero", win_x, 0);
        check("R5 y zero", win_y, 0);
        host_write(8'h08, 32'h055);
        host_write(8'h00, 32'h3333_3333);
        check("R5 push discarded", fifo_empty, 1);
        host_write(8'h04, 32'h2);
        model_soft = 0;
        frame_pulse();
        check("R5 shadow x zero", win_x, 0);
        check("R5 shadow y zero", win_y, 0);

        // R1 normal operation after soft reset
        host_write(8'h00, 32'hC0DE_0042);
        check("R1 stored after release", fifo_empty, 0);
        pix_read();
        check("R1 drained", fifo_empty, 1);
        check("R1 scoreboard empty", exp_q.size(), 0);

        done = 1;
        summary();
    end
endmodule